// File: doc/BRIEF.md
# Flash Identification Probe Sequencer

This block runs the identification handshake of a byte-wide parallel flash device over a simple bus master port. After a start pulse it writes a three-step unlock-and-command sequence that switches the device into identification mode. It then reads the manufacturer and device bytes. A byte of 0x7F is taken as a continuation code, and one further byte is read to extend that identifier to 16 bits. A second command sequence returns the device to normal array mode. The same locations are then read again with the same continuation rule.

When the probe ends, the block reports both extended identifiers. It also reports whether they equal the expected values supplied at its inputs, and whether the manufacturer byte fails an odd-parity check. For each identifier, a flag shows that the value equals the array data read back after exit, which suggests the device never entered identification mode. All waits are counted in pulses of a microsecond tick input, so the same logic serves any system clock.

Top module: `flash_id_probe`

## Requirements
- R1: After a start pulse the block writes 0xAA to offset 0x5555, then 0x55 to offset 0x2AAA, then 0x90 to offset 0x5555, before any read.
- R2: After the first two writes of each command sequence the next bus request waits GAP_US tick pulses. After the 0x90 write it waits ENTRY_WAIT_US pulses, and after the 0xF0 write it waits EXIT_WAIT_US pulses. Each wait is counted from the cycle after the write's acknowledge.
- R3: In identification mode the block reads offset 0, then offset 1. It then reads offset 0x100 only if the byte at offset 0 was 0x7F, and offset 0x101 only if the byte at offset 1 was 0x7F.
- R4: Each identifier output is {0x7F, continuation byte} when a continuation occurred, and otherwise the byte zero-extended to 16 bits.
- R5: After the identification reads the block writes 0xAA to 0x5555, 0x55 to 0x2AAA and 0xF0 to 0x5555. It then rereads offsets 0, 1, 0x100 and 0x101 under the same rule as R3, with the decision taken on the reread bytes.
- R6: parity_err is 1 when the low byte of the manufacturer identifier has an even number of ones.
- R7: mfr_is_array and dev_is_array are 1 when the respective identifier equals the 16-bit value built from the reread after exit.
- R8: id_match is 1 only when both identifiers equal exp_mfr and exp_dev.
- R9: busy is high from the cycle after an accepted start until the probe ends, and then done rises. A start while busy is ignored. All result outputs and done hold their values until the next start, which clears done.
- R10: After reset busy, done, bus_req and all result outputs are 0, and no bus request is made while the block is idle.
- R11: A bus request keeps bus_req, bus_we, bus_addr and bus_wdata unchanged until bus_ack. Read data is taken in the cycle bus_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a probe when idle |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| exp_mfr | input | 16 | Expected manufacturer identifier |
| exp_dev | input | 16 | Expected device identifier |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Byte offset into the flash window |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Transfer acknowledge |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished, results valid |
| mfr_id | output | 16 | Extended manufacturer identifier |
| dev_id | output | 16 | Extended device identifier |
| id_match | output | 1 | Both identifiers equal the expected ones |
| parity_err | output | 1 | Manufacturer byte fails odd parity |
| mfr_is_array | output | 1 | Manufacturer identifier equals array data |
| dev_is_array | output | 1 | Device identifier equals array data |

## Verification
The hardest case to reach is a mixed one. One identifier continues and the other does not, while the array data reread after exit follows a different continuation pattern. Only then do the conditional reads of 0x100 and 0x101 diverge between the two phases. The bench's flash model returns 0x7F for about a third of its bytes and keeps separate identification and array contents. A quarter of the random probes copy the identification bytes into the array, which mimics a device that ignores the unlock sequence. Directed cases cover both continuations, a bad parity byte, and a second start issued mid-probe.

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int AW            = 16,
  parameter int GAP_US        = 10,
  parameter int ENTRY_WAIT_US = 10000,
  parameter int EXIT_WAIT_US  = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick_us,
  input  logic [15:0]   exp_mfr,
  input  logic [15:0]   exp_dev,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  output logic          done,
  output logic [15:0]   mfr_id,
  output logic [15:0]   dev_id,
  output logic          id_match,
  output logic          parity_err,
  output logic          mfr_is_array,
  output logic          dev_is_array
);
  localparam int MAXW = (ENTRY_WAIT_US > EXIT_WAIT_US ? ENTRY_WAIT_US : EXIT_WAIT_US) > GAP_US
                      ? (ENTRY_WAIT_US > EXIT_WAIT_US ? ENTRY_WAIT_US : EXIT_WAIT_US) : GAP_US;
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [3:0] FIN  = 4'd14;
  localparam logic [7:0] CONT = 8'h7F;

  logic [3:0]    step;
  logic          waiting;
  logic [CW-1:0] cnt;
  logic [15:0]   m_id, d_id, m_re, d_re;

  logic          op_we, op_skip;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic [CW-1:0] op_wait;

  always_comb begin
    op_we   = 1'b0;
    op_skip = 1'b0;
    op_addr = '0;
    op_data = 8'h00;
    op_wait = CW'(GAP_US);
    case (step)
      4'd0, 4'd7: begin op_we = 1'b1; op_addr = AW'(16'h5555); op_data = 8'hAA; end
      4'd1, 4'd8: begin op_we = 1'b1; op_addr = AW'(16'h2AAA); op_data = 8'h55; end
      4'd2: begin op_we = 1'b1; op_addr = AW'(16'h5555); op_data = 8'h90; op_wait = CW'(ENTRY_WAIT_US); end
      4'd9: begin op_we = 1'b1; op_addr = AW'(16'h5555); op_data = 8'hF0; op_wait = CW'(EXIT_WAIT_US); end
      4'd3, 4'd10: op_addr = AW'(16'h0000);
      4'd4, 4'd11: op_addr = AW'(16'h0001);
      4'd5:  begin op_addr = AW'(16'h0100); op_skip = (m_id[7:0] != CONT); end
      4'd6:  begin op_addr = AW'(16'h0101); op_skip = (d_id[7:0] != CONT); end
      4'd12: begin op_addr = AW'(16'h0100); op_skip = (m_re[7:0] != CONT); end
      4'd13: begin op_addr = AW'(16'h0101); op_skip = (d_re[7:0] != CONT); end
      default: op_skip = 1'b1;
    endcase
  end

  assign bus_req   = busy && !waiting && (step != FIN) && !op_skip;
  assign bus_we    = op_we;
  assign bus_addr  = op_addr;
  assign bus_wdata = op_data;
  assign mfr_id    = m_id;
  assign dev_id    = d_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; step <= '0; waiting <= 1'b0; cnt <= '0;
      m_id <= '0; d_id <= '0; m_re <= '0; d_re <= '0;
      id_match <= 1'b0; parity_err <= 1'b0; mfr_is_array <= 1'b0; dev_is_array <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; done <= 1'b0; step <= '0; waiting <= 1'b0; cnt <= '0;
        m_id <= '0; d_id <= '0; m_re <= '0; d_re <= '0;
        id_match <= 1'b0; parity_err <= 1'b0; mfr_is_array <= 1'b0; dev_is_array <= 1'b0;
      end
    end else if (step == FIN) begin
      busy         <= 1'b0;
      done         <= 1'b1;
      parity_err   <= ~^m_id[7:0];
      mfr_is_array <= (m_id == m_re);
      dev_is_array <= (d_id == d_re);
      id_match     <= (m_id == exp_mfr) && (d_id == exp_dev);
    end else if (waiting) begin
      if (tick_us) begin
        if (cnt == op_wait - CW'(1)) begin
          waiting <= 1'b0;
          cnt     <= '0;
          step    <= step + 4'd1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end else if (op_skip) begin
      step <= step + 4'd1;
    end else if (bus_ack) begin
      if (op_we) begin
        waiting <= 1'b1;
        cnt     <= '0;
      end else begin
        case (step)
          4'd3:  m_id <= {8'h00, bus_rdata};
          4'd4:  d_id <= {8'h00, bus_rdata};
          4'd5:  m_id <= {m_id[7:0], bus_rdata};
          4'd6:  d_id <= {d_id[7:0], bus_rdata};
          4'd10: m_re <= {8'h00, bus_rdata};
          4'd11: d_re <= {8'h00, bus_rdata};
          4'd12: m_re <= {m_re[7:0], bus_rdata};
          4'd13: d_re <= {d_re[7:0], bus_rdata};
          default: ;
        endcase
        step <= step + 4'd1;
      end
    end
  end
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_ack,
  input logic          busy,
  input logic          done,
  input logic [15:0]   mfr_id,
  input logic [15:0]   dev_id,
  input logic          id_match,
  input logic          parity_err,
  input logic          mfr_is_array,
  input logic          dev_is_array
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  assert_cmd_bytes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we |-> (bus_wdata == 8'hAA || bus_wdata == 8'h55 ||
                           bus_wdata == 8'h90 || bus_wdata == 8'hF0));

  assert_start_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(mfr_id) && $stable(dev_id) && $stable(id_match) &&
                       $stable(parity_err) && $stable(mfr_is_array) && $stable(dev_is_array));

  assert_ext_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mfr_id[15:8] == 8'h00 || mfr_id[15:8] == 8'h7F) &&
             (dev_id[15:8] == 8'h00 || dev_id[15:8] == 8'h7F));
endmodule

bind flash_id_probe flash_id_probe_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .busy(busy),
  .done(done), .mfr_id(mfr_id), .dev_id(dev_id), .id_match(id_match),
  .parity_err(parity_err), .mfr_is_array(mfr_is_array), .dev_is_array(dev_is_array)
);

// File: tb/flash_id_probe_tb.sv
module flash_id_probe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int GAP  = 10;
  localparam int IDW  = 300;
  localparam int EXW  = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick_us = 1'b1;
  logic [15:0] exp_mfr = '0, exp_dev = '0;
  logic bus_req, bus_we, bus_ack, busy, done;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [15:0] mfr_id, dev_id;
  logic id_match, parity_err, mfr_is_array, dev_is_array;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_id_probe #(.AW(AW), .GAP_US(GAP), .ENTRY_WAIT_US(IDW), .EXIT_WAIT_US(EXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_us(tick_us),
    .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .mfr_id(mfr_id), .dev_id(dev_id),
    .id_match(id_match), .parity_err(parity_err),
    .mfr_is_array(mfr_is_array), .dev_is_array(dev_is_array)
  );

  int nchk = 0, nerr = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // flash model: slots 0,1,0x100,0x101
  logic [7:0] idb [4];
  logic [7:0] arb [4];
  logic idm;
  int stage, lat;

  function automatic logic [7:0] mem_rd(input logic [AW-1:0] a, input logic im);
    int k;
    k = (a == 16'h0) ? 0 : (a == 16'h1) ? 1 : (a == 16'h100) ? 2 : (a == 16'h101) ? 3 : -1;
    if (k < 0) return 8'hFF;
    return im ? idb[k] : arb[k];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_rdata <= 8'h00; idm <= 1'b0; stage <= 0; lat <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      if (lat == 0) begin
        bus_ack <= 1'b1;
        lat <= int'($urandom % 3);
        if (bus_we) begin
          if (bus_wdata == 8'hAA && bus_addr == 16'h5555) stage <= 1;
          else if (stage == 1 && bus_wdata == 8'h55 && bus_addr == 16'h2AAA) stage <= 2;
          else begin
            if (stage == 2 && bus_addr == 16'h5555) begin
              if (bus_wdata == 8'h90) idm <= 1'b1;
              if (bus_wdata == 8'hF0) idm <= 1'b0;
            end
            stage <= 0;
          end
        end else begin
          bus_rdata <= mem_rd(bus_addr, idm);
        end
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // bus monitor
  int cyc = 0;
  always @(posedge clk) cyc++;
  logic [23:0] wlog [16];
  logic [15:0] rlog [16];
  int wn = 0, rn = 0, last_ack_cyc = 0;
  bit last_wr = 0, prev_req = 0, prev_ack = 0;

  function automatic int gap_exp(input int idx);
    case (idx)
      2: return IDW + 1;
      5: return EXW + 1;
      default: return GAP + 1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && (!prev_req || prev_ack)) begin
        if (last_wr && wn >= 1 && wn <= 6)
          chk($sformatf("R2 wait after write %0d", wn - 1), cyc - last_ack_cyc, gap_exp(wn - 1));
        last_wr = 0;
      end
      if (bus_req && bus_ack) begin
        if (bus_we) begin
          if (wn < 16) wlog[wn] = {bus_addr, bus_wdata};
          wn++; last_wr = 1; last_ack_cyc = cyc;
        end else begin
          if (rn < 16) rlog[rn] = bus_addr;
          rn++; last_wr = 0;
        end
      end
    end
    prev_req = bus_req;
    prev_ack = bus_ack;
  end

  function automatic logic [15:0] ext(input logic [7:0] b, input logic [7:0] c);
    return (b == 8'h7F) ? {8'h7F, c} : {8'h00, b};
  endfunction

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) chk("R9 probe completion watchdog", 0, 1);
  endtask

  task automatic run_probe(input logic [7:0] i0, i1, i2, i3, a0, a1, a2, a3,
                           input logic [15:0] em_in, ed_in, input bit restart);
    logic [15:0] em, ed, rm, rd;
    logic [15:0] rexp [8];
    int rc;
    @(negedge clk);
    idb[0] = i0; idb[1] = i1; idb[2] = i2; idb[3] = i3;
    arb[0] = a0; arb[1] = a1; arb[2] = a2; arb[3] = a3;
    exp_mfr = em_in; exp_dev = ed_in;
    wn = 0; rn = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R9 busy after start", {busy, done}, 2'b10);
    if (restart) begin
      repeat (40) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    wait_done();
    em = ext(i0, i2); ed = ext(i1, i3); rm = ext(a0, a2); rd = ext(a1, a3);
    chk("R1 entry write count", wn, 6);
    chk("R1 entry write 0", wlog[0], 24'h5555AA);
    chk("R1 entry write 1", wlog[1], 24'h2AAA55);
    chk("R1 entry write 2", wlog[2], 24'h555590);
    chk("R5 exit write 0", wlog[3], 24'h5555AA);
    chk("R5 exit write 1", wlog[4], 24'h2AAA55);
    chk("R5 exit write 2", wlog[5], 24'h5555F0);
    rc = 0;
    rexp[rc++] = 16'h0; rexp[rc++] = 16'h1;
    if (i0 == 8'h7F) rexp[rc++] = 16'h100;
    if (i1 == 8'h7F) rexp[rc++] = 16'h101;
    rexp[rc++] = 16'h0; rexp[rc++] = 16'h1;
    if (a0 == 8'h7F) rexp[rc++] = 16'h100;
    if (a1 == 8'h7F) rexp[rc++] = 16'h101;
    chk("R3 R5 read count", rn, rc);
    for (int k = 0; k < rc && k < rn; k++)
      chk($sformatf("R3 R5 read address %0d", k), rlog[k], rexp[k]);
    chk("R4 manufacturer id", mfr_id, em);
    chk("R4 device id", dev_id, ed);
    chk("R6 parity flag", parity_err, ~^em[7:0]);
    chk("R7 manufacturer array flag", mfr_is_array, em == rm);
    chk("R7 device array flag", dev_is_array, ed == rd);
    chk("R8 match flag", id_match, (em == em_in) && (ed == ed_in));
    chk("R9 done and idle", {busy, done}, 2'b01);
  endtask

  function automatic logic [7:0] rb();
    return ($urandom % 3 == 0) ? 8'h7F : 8'($urandom);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL R9 global watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    logic [15:0] hm, hd;
    logic [3:0] hf;
    void'($urandom(32'd7));
    for (int k = 0; k < 4; k++) begin idb[k] = 8'hFF; arb[k] = 8'hFF; end
    repeat (3) @(negedge clk);
    chk("R10 reset state", {busy, done, bus_req, id_match, parity_err, mfr_is_array, dev_is_array}, 7'b0);
    chk("R10 reset ids", {mfr_id, dev_id}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 idle no request", bus_req, 1'b0);

    // plain ids, good parity, match
    run_probe(8'h1F, 8'hDA, 8'h00, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 16'h001F, 16'h00DA, 0);
    // hold check
    hm = mfr_id; hd = dev_id; hf = {id_match, parity_err, mfr_is_array, dev_is_array};
    @(negedge clk); idb[0] = 8'h55; exp_mfr = 16'hBEEF;
    repeat (20) @(negedge clk);
    chk("R9 outputs held after done", {mfr_id, dev_id}, {hm, hd});
    chk("R9 flags held after done", {done, id_match, parity_err, mfr_is_array, dev_is_array}, {1'b1, hf});
    // both continue
    run_probe(8'h7F, 8'h7F, 8'h20, 8'h0E, 8'h7F, 8'h01, 8'h33, 8'h44, 16'h7F20, 16'h7F0E, 0);
    // chip ignores unlock: array equals ids, bad parity byte, only device continues
    run_probe(8'h03, 8'h7F, 8'h99, 8'h5A, 8'h03, 8'h7F, 8'h99, 8'h5A, 16'h0003, 16'h1234, 0);
    // start while busy ignored
    run_probe(8'hC2, 8'h7F, 8'h11, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 16'h00C2, 16'h7F7F, 1);

    for (int n = 0; n < 24; n++) begin
      logic [7:0] b0, b1, b2, b3, c0, c1, c2, c3;
      logic [15:0] xm, xd;
      b0 = rb(); b1 = rb(); b2 = rb(); b3 = rb();
      if ($urandom % 4 == 0) begin c0 = b0; c1 = b1; c2 = b2; c3 = b3; end
      else begin c0 = rb(); c1 = rb(); c2 = rb(); c3 = rb(); end
      xm = ext(b0, b2); xd = ext(b1, b3);
      if ($urandom % 2 == 0) xm = xm ^ 16'(1 << ($urandom % 16));
      if ($urandom % 3 == 0) xd = 16'($urandom);
      run_probe(b0, b1, b2, b3, c0, c1, c2, c3, xm, xd, 0);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule